// File: doc/BRIEF.md
# Link-Event Application Reset Generator

This block sits beside a PCIe endpoint core and turns the core's short link-event strobes into an application-layer reset that lasts long enough to be useful. Three active-low, single-cycle strobes are watched: loss of the data-link Up state, exit from hot reset, and the return from the L2 low-power state to Detect. Any one of them starts a registered reset that holds for at least `MIN_HOLD` clock cycles. A further strobe that arrives while the hold is still running starts the count again.

The core also reports parity problems: a configuration-path error, an RX-buffer error, and a two-bit TX code. An error seen by the transaction layer nullifies the packet. An error caught later by the data-link stage is fatal. Fatal parity errors do not drive the application reset. They raise a sticky request that the endpoint core itself be reset, and this request holds until the power-on reset. Every event also sets a sticky cause bit, which software clears with a write-one-to-clear vector. All inputs are synchronous to `clk`. All pins are plain control and status lines, so the block has no stream interface and applies no back-pressure.

Top module: `link_rst_gen`

## Requirements
- R1: While `por_n` is low, `app_rst` is 1, `core_rst_req` is 0 and `cause` is all zero. After `por_n` rises, `app_rst` stays 1 for exactly `MIN_HOLD` further rising edges and then falls.
- R2: A 0 on `dl_exit_n`, `hot_exit_n` or `l2_exit_n`, sampled at a rising edge, drives `app_rst` to 1 from that edge for exactly `MIN_HOLD` cycles.
- R3: A strobe that arrives while `app_rst` is held restarts the full `MIN_HOLD`-cycle count from the edge where it is sampled.
- R4: Strobe inputs that stay high have no effect on `app_rst`. Two or three strobes in the same cycle act exactly like one.
- R5: `cause` bit positions are: 0 data-link exit, 1 hot-reset exit, 2 L2 exit, 3 configuration parity, 4 RX parity, 5 TX code bit 1 (transaction-layer error, code 2'b10), 6 TX code bit 0 (data-link error, code 2'b01). Each bit is set from the edge after its event is sampled. Code 2'b11 sets both bits 5 and 6.
- R6: A 1 on `cause_clr[i]` clears `cause[i]` at that edge. If bit i is set and cleared in the same cycle, the set wins.
- R7: `cfg_perr`, `rx_perr` or `tx_perr[0]` high at an edge sets `core_rst_req` from that edge. The request stays 1 until `por_n` goes low.
- R8: No parity input ever changes `app_rst`. A TX code of 2'b10 alone does not raise `core_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dl_exit_n | input | 1 | Data-link Up-state exit strobe, active low |
| hot_exit_n | input | 1 | Hot-reset exit strobe, active low |
| l2_exit_n | input | 1 | L2-to-Detect exit strobe, active low |
| cfg_perr | input | 1 | Configuration-path parity error |
| rx_perr | input | 1 | RX-buffer parity error, single-cycle |
| tx_perr | input | 2 | TX parity code: 2'b10 transaction layer, 2'b01 data-link stage |
| cause_clr | input | 7 | Write-one-to-clear for `cause` |
| app_rst | output | 1 | Stretched application reset, active high, registered |
| core_rst_req | output | 1 | Sticky request to reset the endpoint core |
| cause | output | 7 | Sticky cause bits |

## Verification
The bench builds the block with `MIN_HOLD` = 4. With this short hold it can sweep every strobe line against every restart gap, from 1 cycle up to one beyond the hold, at low cost. The bench also applies all 16 combinations of the four parity input bits, each after a fresh power-on reset. Each cycle it compares the outputs with an arithmetic count-down and sticky-bit model. This checks the exact fall edge of the reset, restarts at every offset, and the split between fatal and non-fatal TX codes.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  localparam int NUM_CAUSE   = 7;
  localparam int NUM_LINK    = 3;
  localparam int CZ_DL_EXIT  = 0;
  localparam int CZ_HOT_EXIT = 1;
  localparam int CZ_L2_EXIT  = 2;
  localparam int CZ_CFG_PAR  = 3;
  localparam int CZ_RX_PAR   = 4;
  localparam int CZ_TX_TL    = 5;
  localparam int CZ_TX_DL    = 6;

  typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/lrg_evt_decode.sv
module lrg_evt_decode
  import lrg_pkg::*;
(
  input  logic       dl_exit_n,
  input  logic       hot_exit_n,
  input  logic       l2_exit_n,
  input  logic       cfg_perr,
  input  logic       rx_perr,
  input  logic [1:0] tx_perr,
  output cause_vec_t evt,
  output logic       link_trig,
  output logic       fatal
);
  logic [NUM_LINK-1:0] link_hit;

  always_comb begin
    link_hit[CZ_DL_EXIT]  = ~dl_exit_n;
    link_hit[CZ_HOT_EXIT] = ~hot_exit_n;
    link_hit[CZ_L2_EXIT]  = ~l2_exit_n;
  end

  always_comb begin
    evt                   = '0;
    evt[NUM_LINK-1:0]     = link_hit;
    evt[CZ_CFG_PAR]       = cfg_perr;
    evt[CZ_RX_PAR]        = rx_perr;
    evt[CZ_TX_TL]         = tx_perr[1];
    evt[CZ_TX_DL]         = tx_perr[0];
  end

  assign link_trig = |link_hit;
  // transaction-layer TX code alone is recoverable: packet already nullified
  assign fatal     = cfg_perr | rx_perr | tx_perr[0];
endmodule

// File: rtl/lrg_hold_timer.sv
module lrg_hold_timer #(
  parameter int HOLD = 32
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic hold_o
);
  localparam int CW  = $clog2(HOLD + 1);
  localparam int KW  = $clog2(HOLD + 2);

  logic [CW-1:0] rem_q, rem_d;
  logic          hold_q;

  always_comb begin
    if (trig)
      rem_d = CW'(HOLD);
    else if (rem_q != '0)
      rem_d = rem_q - 1'b1;
    else
      rem_d = rem_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rem_q  <= CW'(HOLD);
      hold_q <= 1'b1;
    end else begin
      rem_q  <= rem_d;
      hold_q <= (rem_d != '0);
    end
  end

  assign hold_o = hold_q;

  // independent length counter used only by the checks below
  logic [KW-1:0] seen_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      seen_q <= KW'(1);
    else if (trig)
      seen_q <= KW'(1);
    else if (hold_q && (int'(seen_q) < HOLD + 1))
      seen_q <= seen_q + 1'b1;
  end

  // R2
  trig_asserts_chk: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> hold_q);
  // R3
  hold_min_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(hold_q) |-> (int'(seen_q) >= HOLD));
  // R4
  stay_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!hold_q && !trig) |=> !hold_q);
endmodule

// File: rtl/lrg_cause_bank.sv
module lrg_cause_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
        bit_q <= 1'b0;
      else if (set_i[i])
        bit_q <= 1'b1;
      else if (clr_i[i])
        bit_q <= 1'b0;
    end
    assign cause_o[i] = bit_q;
  end

  // R5
  cause_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i)));
  // R6
  cause_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((clr_i & ~set_i) != '0) |=> ((cause_o & $past(clr_i & ~set_i)) == '0));
  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!por_n)
    (set_i == '0) |=> ((cause_o & ~$past(cause_o)) == '0));
endmodule

// File: rtl/link_rst_gen.sv
module link_rst_gen
  import lrg_pkg::*;
#(
  parameter int MIN_HOLD = 32
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 dl_exit_n,
  input  logic                 hot_exit_n,
  input  logic                 l2_exit_n,
  input  logic                 cfg_perr,
  input  logic                 rx_perr,
  input  logic [1:0]           tx_perr,
  input  logic [NUM_CAUSE-1:0] cause_clr,
  output logic                 app_rst,
  output logic                 core_rst_req,
  output logic [NUM_CAUSE-1:0] cause
);
  cause_vec_t evt;
  logic       link_trig;
  logic       fatal;
  logic       core_q;

  lrg_evt_decode u_dec (
    .dl_exit_n (dl_exit_n),
    .hot_exit_n(hot_exit_n),
    .l2_exit_n (l2_exit_n),
    .cfg_perr  (cfg_perr),
    .rx_perr   (rx_perr),
    .tx_perr   (tx_perr),
    .evt       (evt),
    .link_trig (link_trig),
    .fatal     (fatal)
  );

  lrg_hold_timer #(.HOLD(MIN_HOLD)) u_hold (
    .clk   (clk),
    .por_n (por_n),
    .trig  (link_trig),
    .hold_o(app_rst)
  );

  lrg_cause_bank #(.N(NUM_CAUSE)) u_cause (
    .clk    (clk),
    .por_n  (por_n),
    .set_i  (evt),
    .clr_i  (cause_clr),
    .cause_o(cause)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      core_q <= 1'b0;
    else if (fatal)
      core_q <= 1'b1;
  end

  assign core_rst_req = core_q;

  // R7
  core_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_req |=> core_rst_req);
  // R7
  core_raise_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_perr || rx_perr) |=> core_rst_req);
  // R8
  tl_nonfatal_chk: assert property (@(posedge clk) disable iff (!por_n)
    (tx_perr == 2'b10 && !cfg_perr && !rx_perr && !core_rst_req) |=> !core_rst_req);
  // R8
  parity_no_app_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!app_rst && dl_exit_n && hot_exit_n && l2_exit_n) |=> !app_rst);
endmodule

// File: tb/link_rst_gen_tb_top.sv
module link_rst_gen_tb_top;
  localparam int MIN = 4;
  localparam int NC  = 7;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [2:0]    ex_n = 3'b111;
  logic          cfg_perr = 1'b0;
  logic          rx_perr = 1'b0;
  logic [1:0]    tx_perr = 2'b00;
  logic [NC-1:0] cause_clr = '0;
  logic          app_rst;
  logic          core_rst_req;
  logic [NC-1:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  int            m_rem;
  logic [NC-1:0] m_cause;
  logic          m_core;

  always #10 clk = ~clk;

  link_rst_gen #(.MIN_HOLD(MIN)) dut_i (
    .clk         (clk),
    .por_n       (por_n),
    .dl_exit_n   (ex_n[0]),
    .hot_exit_n  (ex_n[1]),
    .l2_exit_n   (ex_n[2]),
    .cfg_perr    (cfg_perr),
    .rx_perr     (rx_perr),
    .tx_perr     (tx_perr),
    .cause_clr   (cause_clr),
    .app_rst     (app_rst),
    .core_rst_req(core_rst_req),
    .cause       (cause)
  );

  // arithmetic reference model
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_rem   = MIN;
      m_cause = '0;
      m_core  = 1'b0;
    end else begin
      logic [NC-1:0] setv;
      setv = {tx_perr[0], tx_perr[1], rx_perr, cfg_perr, ~ex_n};
      if (ex_n != 3'b111) m_rem = MIN;
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_cause = (m_cause & ~cause_clr) | setv;
      if (cfg_perr || rx_perr || tx_perr[0]) m_core = 1'b1;
    end
  end

  task automatic check_all();
    checks += 3;
    if (app_rst !== (m_rem > 0)) begin
      failures++;
      $display("FAIL %s app_rst actual=%b expected=%b", tag, app_rst, m_rem > 0);
    end
    if (core_rst_req !== m_core) begin
      failures++;
      $display("FAIL %s core_rst_req actual=%b expected=%b", tag, core_rst_req, m_core);
    end
    if (cause !== m_cause) begin
      failures++;
      $display("FAIL %s cause actual=%b expected=%b", tag, cause, m_cause);
    end
  endtask

  task automatic cyc(input logic [2:0] e, input logic c, input logic r,
                     input logic [1:0] t, input logic [NC-1:0] clr);
    @(negedge clk);
    check_all();
    ex_n = e; cfg_perr = c; rx_perr = r; tx_perr = t; cause_clr = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'b111, 1'b0, 1'b0, 2'b00, '0);
  endtask

  task automatic strobe(input int s);
    cyc(~(3'b001 << s), 1'b0, 1'b0, 2'b00, '0);
  endtask

  task automatic por();
    @(negedge clk);
    ex_n = 3'b111; cfg_perr = 0; rx_perr = 0; tx_perr = 0; cause_clr = '0;
    por_n = 1'b0;
    tag = "R1";
    for (int i = 0; i < 2; i++) begin @(negedge clk); check_all(); end
    por_n = 1'b1;
  endtask

  initial begin
    // R1: reset state and hold after release
    for (int i = 0; i < 3; i++) begin @(negedge clk); check_all(); end
    por_n = 1'b1;
    idle(MIN + 3);

    // R2: every strobe line alone
    tag = "R2";
    for (int s = 0; s < 3; s++) begin strobe(s); idle(MIN + 2); end

    // R3: restart at every gap
    tag = "R3";
    for (int s = 0; s < 3; s++)
      for (int g = 1; g <= MIN + 1; g++) begin
        strobe(s);
        idle(g - 1);
        strobe((s + 1) % 3);
        idle(MIN + 2);
      end

    // R4: no strobe, then simultaneous strobes
    tag = "R4";
    cyc(3'b111, 0, 0, 2'b00, {NC{1'b1}});
    idle(MIN + 2);
    cyc(3'b000, 0, 0, 2'b00, '0);
    idle(MIN + 2);
    cyc(3'b100, 0, 0, 2'b00, '0);
    idle(MIN + 2);

    // R5 / R7 / R8: all parity input combinations
    for (int k = 0; k < 16; k++) begin
      por();
      idle(MIN + 2);
      if (k[3:2] == 2'b00 && k[1:0] == 2'b10) tag = "R8";
      else if (k[3] || k[2] || k[0]) tag = "R7";
      else tag = "R5";
      cyc(3'b111, k[3], k[2], k[1:0], '0);
      idle(3);
      tag = "R6";
      cyc(3'b111, 0, 0, 2'b00, {NC{1'b1}});
      idle(2);
    end

    // R6: set and clear collide, then clear alone
    tag = "R6";
    cyc(3'b110, 0, 0, 2'b00, 7'b0000001);
    idle(1);
    cyc(3'b111, 0, 1, 2'b00, 7'b0010001);
    idle(MIN + 2);
    cyc(3'b111, 0, 0, 2'b00, 7'b1111111);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule